// File: doc/BRIEF.md
# Shared Instruction/Data Port Fetch Arbiter

This block sits at the front of a five-stage integer pipeline whose instruction fetch and data accesses go through one single-ported memory. Each cycle it decides who owns that port. When a valid load or store sits in the memory-access stage, that older instruction wins. The fetch for that cycle is dropped, the program counter and the fetch/decode register are frozen, and the decode stage sees an invalid slot, which is a bubble. In every other cycle the port fetches at the program counter.

The conflict decision is combinational on the memory-stage inputs, so the port address, the write strobe and the freeze enables are valid in the same cycle. Only the valid flag of the fetch/decode register is a flop. Stages downstream of the memory stage are not controlled here and keep moving. Every conflict therefore costs exactly one fetch slot. The asynchronous active-low reset is released through a two-flop synchronizer. The block stays idle until the second clock edge after release.

Top module: `shared_port_fetch_arb`

## Requirements
- R1: While rst_n is low, and until the second rising clock edge after it rises, port_req_o, port_we_o, port_is_data_o, pc_en_o, ifid_en_o, stall_o and ifid_vld_o are all 0.
- R2: The memory-stage class uses this encoding: 2'b01 is a load, 2'b10 is a store, and 2'b00 and 2'b11 are non-memory. Once running, stall_o is 1 in the same cycle exactly when ms_vld_i is 1 and the class is a load or a store.
- R3: During a load conflict, port_is_data_o is 1, port_addr_o equals ms_addr_i, port_we_o is 0 and port_req_o is 1.
- R4: During a store conflict, port_is_data_o is 1, port_addr_o equals ms_addr_i, port_we_o is 1 and port_req_o is 1.
- R5: In a running cycle with no conflict, port_req_o is 1, port_is_data_o is 0, port_we_o is 0 and port_addr_o equals pc_i.
- R6: In a conflict cycle, pc_en_o and ifid_en_o are both 0. In a running cycle without a conflict, both are 1.
- R7: After each rising edge while running, ifid_vld_o is 0 if the previous cycle was a conflict and 1 if it was a fetch.
- R8: A load or store class with ms_vld_i at 0 causes no conflict and leaves the port on the fetch address.
- R9: A run of N consecutive valid memory references stalls in each of those N cycles, and fetch resumes in the first cycle after the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_vld_i | input | 1 | Memory-stage slot holds a real instruction |
| ms_cls_i | input | 2 | Memory-stage opcode class (see R2) |
| ms_addr_i | input | ADDR_W | Data address from the memory stage |
| pc_i | input | ADDR_W | Current fetch address |
| port_req_o | output | 1 | Memory port request |
| port_we_o | output | 1 | Memory port write strobe |
| port_is_data_o | output | 1 | Port serves the data access this cycle |
| port_addr_o | output | ADDR_W | Memory port address |
| pc_en_o | output | 1 | Program counter update enable |
| ifid_en_o | output | 1 | Fetch/decode register load enable |
| stall_o | output | 1 | Conflict this cycle; a bubble follows |
| ifid_vld_o | output | 1 | Fetch/decode register holds a valid instruction |

## Verification
The port address, request, write strobe, enables and stall_o are combinational outputs, so they are due in the same cycle as the memory-stage inputs. The bench drives inputs on a falling edge and compares them 1 ns later, before the next rising edge. ifid_vld_o sits one register away and is due after the following rising edge. The bench compares it 1 ns after that edge. Leaving reset takes two synchronizer edges, and the bench checks the idle state after the first edge and the running state after the second.

// File: rtl/upf_pkg.sv
package upf_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_CTRL  = 2'b11
  } ms_cls_e;

  function automatic logic cls_is_memref(input ms_cls_e c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction

endpackage

// File: rtl/upf_rst_sync.sv
module upf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/upf_conflict.sv
module upf_conflict
  import upf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ms_vld_i,
  input  logic [1:0] ms_cls_i,
  output logic conflict_o,
  output logic is_store_o
);
  ms_cls_e cls;

  always_comb begin
    cls        = ms_cls_e'(ms_cls_i);
    conflict_o = run_i && ms_vld_i && cls_is_memref(cls);
    is_store_o = conflict_o && (cls == CLS_STORE);
  end

  // R8: an empty memory-stage slot never takes the port
  a_r8_invalid_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_vld_i |-> !conflict_o);
endmodule

// File: rtl/upf_port_mux.sv
module upf_port_mux #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              conflict_i,
  input  logic              is_store_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ms_addr_i,
  output logic              req_o,
  output logic              we_o,
  output logic              is_data_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    req_o     = run_i;
    is_data_o = conflict_i;
    we_o      = conflict_i && is_store_i;
    addr_o    = conflict_i ? ms_addr_i : pc_i;
  end

  // R4: a write is only issued on behalf of the data side
  a_r4_write_is_data: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (is_data_o && req_o));
  // R1: no port activity while idle
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (!req_o && !we_o));
endmodule

// File: rtl/upf_fetch_gate.sv
module upf_fetch_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic conflict_i,
  output logic pc_en_o,
  output logic ifid_en_o,
  output logic stall_o,
  output logic ifid_vld_o
);
  logic vld_q, vld_d;
  logic fetch_ok;

  always_comb begin
    fetch_ok  = run_i && !conflict_i;
    pc_en_o   = fetch_ok;
    ifid_en_o = fetch_ok;
    stall_o   = conflict_i;
    vld_d     = vld_q;
    if (!run_i)          vld_d = 1'b0;
    else if (conflict_i) vld_d = 1'b0;
    else                 vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign ifid_vld_o = vld_q;

  // R6: a conflict freezes both fetch-side registers
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (!pc_en_o && !ifid_en_o));
  // R7: the slot after a conflict is a bubble
  a_r7_bubble_next: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !ifid_vld_o);
  // R7: the slot after a fetch is valid
  a_r7_fetch_next: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en_o |=> ifid_vld_o);
endmodule

// File: rtl/shared_port_fetch_arb.sv
module shared_port_fetch_arb #(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_vld_i,
  input  logic [1:0]        ms_cls_i,
  input  logic [ADDR_W-1:0] ms_addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              port_req_o,
  output logic              port_we_o,
  output logic              port_is_data_o,
  output logic [ADDR_W-1:0] port_addr_o,
  output logic              pc_en_o,
  output logic              ifid_en_o,
  output logic              stall_o,
  output logic              ifid_vld_o
);
  logic run;
  logic conflict;
  logic is_store;

  upf_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .run_o(run));

  upf_conflict u_conf (
    .clk(clk), .rst_n(rst_n), .run_i(run), .ms_vld_i(ms_vld_i),
    .ms_cls_i(ms_cls_i), .conflict_o(conflict), .is_store_o(is_store));

  upf_port_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .run_i(run), .conflict_i(conflict),
    .is_store_i(is_store), .pc_i(pc_i), .ms_addr_i(ms_addr_i),
    .req_o(port_req_o), .we_o(port_we_o), .is_data_o(port_is_data_o),
    .addr_o(port_addr_o));

  upf_fetch_gate u_gate (
    .clk(clk), .rst_n(rst_n), .run_i(run), .conflict_i(conflict),
    .pc_en_o(pc_en_o), .ifid_en_o(ifid_en_o), .stall_o(stall_o),
    .ifid_vld_o(ifid_vld_o));

  // R3: the data side owns the address whenever it holds the port
  a_r3_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
    port_is_data_o |-> (port_addr_o == ms_addr_i));
  // R5: fetch cycles present the program counter
  a_r5_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en_o |-> (port_addr_o == pc_i && !port_we_o));
  // R2: port ownership and stall agree
  a_r2_stall_is_data: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o == port_is_data_o);
endmodule

// File: tb/tb_shared_port_fetch_arb.sv
`timescale 1ns/1ps
module tb_shared_port_fetch_arb;
  localparam int AW = 32;
  logic clk = 1'b0;
  logic rst_n;
  logic ms_vld;
  logic [1:0] ms_cls;
  logic [AW-1:0] ms_addr, pc;
  logic req, we, isd, pce, ife, stl, ivld;
  logic [AW-1:0] paddr;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_port_fetch_arb #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ms_vld_i(ms_vld), .ms_cls_i(ms_cls),
    .ms_addr_i(ms_addr), .pc_i(pc), .port_req_o(req), .port_we_o(we),
    .port_is_data_o(isd), .port_addr_o(paddr), .pc_en_o(pce),
    .ifid_en_o(ife), .stall_o(stl), .ifid_vld_o(ivld));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle, check combinational results, then check registered bubble flag
  task automatic step(input logic v, input logic [1:0] c, input logic [AW-1:0] a,
                      input logic [AW-1:0] p, input string tag);
    logic mem, st;
    @(negedge clk);
    ms_vld = v; ms_cls = c; ms_addr = a; pc = p;
    mem = v && (c == 2'b01 || c == 2'b10);
    st  = v && (c == 2'b10);
    #1;
    chk({tag, " stall"}, stl, mem);
    chk({tag, " req"}, req, 1'b1);
    chk({tag, " is_data"}, isd, mem);
    chk({tag, " we"}, we, st);
    chk({tag, " addr"}, paddr, mem ? a : p);
    chk({tag, " pc_en"}, pce, !mem);
    chk({tag, " ifid_en"}, ife, !mem);
    @(posedge clk); #1;
    chk({tag, " R7 ifid_vld"}, ivld, !mem);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ms_vld = 1'b1; ms_cls = 2'b01; ms_addr = 32'h40; pc = 32'h100;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 req in reset", {req, we, isd, pce, ife, stl, ivld}, 7'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle after first edge", {req, we, isd, pce, ife, stl, ivld}, 7'b0);
    ms_vld = 1'b0;
    @(posedge clk); #1;
    chk("R1 running after second edge", {req, pce}, 2'b11);
  endtask

  task automatic t_fetch();
    step(1'b0, 2'b00, 32'h0, 32'h200, "R5 idle slot");
    step(1'b1, 2'b00, 32'h44, 32'h204, "R5 alu op");
    step(1'b1, 2'b11, 32'h48, 32'h208, "R5 ctrl op");
  endtask

  task automatic t_load();  step(1'b1, 2'b01, 32'hA0, 32'h20C, "R3 load"); endtask
  task automatic t_store(); step(1'b1, 2'b10, 32'hB4, 32'h20C, "R4 store"); endtask

  task automatic t_invalid();
    step(1'b0, 2'b01, 32'hC0, 32'h300, "R8 invalid load");
    step(1'b0, 2'b10, 32'hC4, 32'h304, "R8 invalid store");
  endtask

  task automatic t_burst();
    int fetches = 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, (i % 2) ? 2'b10 : 2'b01, 32'h500 + i, 32'h400, "R9 burst");
      fetches += pce;
    end
    chk("R9 no fetch during burst", fetches, 0);
    step(1'b1, 2'b00, 32'h0, 32'h400, "R9 resume");
    chk("R6 fetch resumes", pce, 1'b1);
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 2'b01, 32'h600 + i, 32'h700 + i, "R2 alt mem");
      step(1'b1, 2'b00, 32'h0, 32'h704 + i, "R2 alt alu");
    end
  endtask

  initial begin
    t_reset();
    t_fetch();
    t_load();
    t_store();
    t_invalid();
    t_burst();
    t_alternate();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule